// File: doc/BRIEF.md
# Serial Control Word Port

This block is the serial front end of an output-driver controller. A host frames each transfer with an active-low select. While the select is low, the host shifts a 16-bit control word into the block, least significant bit first, and reads a 16-bit status word back over the same frame. The control word reaches the driver logic only when the select returns high after a complete word. A partial frame therefore leaves every setting untouched. A host can use such a partial frame to glance at status bit 0 alone.

All three serial pins are oversampled by a system clock that runs at least eight times faster than the serial clock. Each pin passes through a two-stage synchronizer and an edge detector. Incoming data is taken on the falling serial-clock edge. Outgoing data moves on the rising edge. The data output carries a separate enable so that several ports can share one return line. Bits shifted past the end of the status word are the incoming bits delayed by one word, which lets ports be chained.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset `ctrl_q` reads 16'hE000 (bits 15, 14 and 13 high, all others low), `sdo_oe` is low and `clear_pulse` is low.
- R2: `sdo_oe` goes high when the select falls and goes low when it rises. While the select is high the output is disabled.
- R3: `status_in` is captured when the select falls, and its bit 0 is on `sdo` before any serial-clock edge.
- R4: `sdi` is sampled on falling serial-clock edges, with the first sampled bit becoming control bit 0.
- R5: The first rising serial-clock edge of a frame leaves `sdo` unchanged. Each later rising edge advances `sdo` to the next status bit, in ascending bit order.
- R6: `ctrl_q` changes only when the select rises after at least 16 falling serial-clock edges. A shorter frame leaves it unchanged.
- R7: In a frame longer than 16 bits, the last 16 bits received are committed. After status bit 15, `sdo` presents the `sdi` bits delayed by exactly 16 bit times.
- R8: A completed word whose bits 15, 14 and 13 are all 1 and whose bits 12 down to 7 are not all 0 is refused: `ctrl_q` is kept and no `clear_pulse` is issued. With bits 12 to 7 all 0, the word is accepted.
- R9: Bit 0 of a committed word is not stored (`ctrl_q[0]` reads 0). When that bit is 1, `clear_pulse` is high for exactly one system-clock cycle at the commit.
- R10: Serial-clock and data activity while the select is high has no effect on `ctrl_q`, on the enable, or on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Frame select from host, active low |
| sclk_pin | input | 1 | Serial clock from host |
| sdi_pin | input | 1 | Serial data in, least significant bit first |
| status_in | input | 16 | Status word to be returned in the next frame |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the shared return line |
| ctrl_q | output | 16 | Committed control word (bit 0 always 0) |
| clear_pulse | output | 1 | One-cycle strobe when a committed word has bit 0 set |

## Verification
The hardest situation to reach is the chained frame. The output has to switch from the status word to the incoming bits delayed by one word, while the commit must keep only the last 16 bits. The stimulus runs a 20-bit frame and predicts all 20 output bits. Each bit is sampled at the host's falling edge, several system clocks after the rising edge that launched it. A select-only frame with no clock edges checks the early status bit. Reserved words just inside and just outside the refusal rule check the pattern decode.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned CNT_W     = $clog2(WORD_W + 1);
  localparam int unsigned SEL_LO    = 7;
  localparam int unsigned SEL_HI    = 12;
  localparam int unsigned MODE_LO   = 13;
  localparam logic [WORD_W-1:0] CTRL_RESET = 16'hE000;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
        prev_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= pins[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end

    always_comb begin
      lvl[g]  = sync_q[g];
      rise[g] = sync_q[g] & ~prev_q[g];
      fall[g] = ~sync_q[g] & prev_q[g];
    end
  end
endmodule

// File: rtl/shift_engine.sv
module shift_engine
  import serial_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sdi,
  input  word_t            status_in,
  output logic             sdo,
  output logic             sdo_oe,
  output word_t            rx_word,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic             active_q, active_d;
  word_t            rx_q, rx_d, tx_q, tx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take_bit, move_out;

  always_comb begin
    take_bit = active_q & sclk_fall;
    move_out = active_q & sclk_rise & (cnt_q != '0);
    active_d = active_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    cnt_d    = cnt_q;
    if (cs_fall) begin
      active_d = 1'b1;
      tx_d     = status_in;
      cnt_d    = '0;
    end else if (cs_rise) begin
      active_d = 1'b0;
    end else begin
      if (take_bit) begin
        rx_d = {sdi, rx_q[WORD_W-1:1]};
        if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
      end
      if (move_out) tx_d = {rx_q[WORD_W-1], tx_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sdo     = active_q & tx_q[0];
  assign sdo_oe  = active_q;
  assign rx_word = rx_q;
  assign bit_cnt = cnt_q;

  assert_oe_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo_oe);
  assert_oe_off_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FULL);
  assert_idle_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !cs_fall) |=> ($stable(rx_word) && $stable(bit_cnt)));
endmodule

// File: rtl/commit_unit.sv
module commit_unit
  import serial_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise,
  input  word_t            rx_word,
  input  logic [CNT_W-1:0] bit_cnt,
  output word_t            ctrl_q,
  output logic             clear_pulse
);
  word_t ctrl_r, ctrl_d;
  logic  pulse_r, pulse_d;
  logic  full, reserved, commit;

  always_comb begin
    full     = (bit_cnt >= CNT_W'(WORD_W));
    reserved = (&rx_word[WORD_W-1:MODE_LO]) & (|rx_word[SEL_HI:SEL_LO]);
    commit   = cs_rise & full & ~reserved;
    ctrl_d   = ctrl_r;
    pulse_d  = 1'b0;
    if (commit) begin
      ctrl_d  = {rx_word[WORD_W-1:1], 1'b0};
      pulse_d = rx_word[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r  <= CTRL_RESET;
      pulse_r <= 1'b0;
    end else begin
      ctrl_r  <= ctrl_d;
      pulse_r <= pulse_d;
    end
  end

  assign ctrl_q      = ctrl_r;
  assign clear_pulse = pulse_r;

  assert_hold_without_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(ctrl_q));
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |=> !clear_pulse);
  assert_no_test_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&ctrl_q[WORD_W-1:MODE_LO]) |-> (ctrl_q[SEL_HI:SEL_LO] == '0));
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import serial_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_pin,
  input  logic        sclk_pin,
  input  logic        sdi_pin,
  input  logic [15:0] status_in,
  output logic        sdo,
  output logic        sdo_oe,
  output logic [15:0] ctrl_q,
  output logic        clear_pulse
);
  logic [2:0]       lvl, rise, fall;
  word_t            rx_word;
  logic [CNT_W-1:0] bit_cnt;

  pin_sync #(.N(3), .RST_VAL(3'b001)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pins ({sdi_pin, sclk_pin, cs_n_pin}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  shift_engine i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_fall  (fall[0]),
    .cs_rise  (rise[0]),
    .sclk_rise(rise[1]),
    .sclk_fall(fall[1]),
    .sdi      (lvl[2]),
    .status_in(status_in),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rx_word  (rx_word),
    .bit_cnt  (bit_cnt)
  );

  commit_unit i_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (rise[0]),
    .rx_word    (rx_word),
    .bit_cnt    (bit_cnt),
    .ctrl_q     (ctrl_q),
    .clear_pulse(clear_pulse)
  );
endmodule

// File: tb/test_serial_ctrl_port.sv
module test_serial_ctrl_port;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sclk_pin = 1'b0, sdi_pin = 1'b0;
  logic [15:0] status_in = '0;
  logic sdo, sdo_oe, clear_pulse;
  logic [15:0] ctrl_q;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;
  logic exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  serial_ctrl_port i_serial_ctrl_port (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
    .sdi_pin(sdi_pin), .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe),
    .ctrl_q(ctrl_q), .clear_pulse(clear_pulse)
  );

  always @(posedge clk) if (clear_pulse) pulses++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: host samples sdo at each falling serial-clock edge
  always @(negedge sclk_pin) begin
    if (!cs_n_pin && exp_q.size() > 0) begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " sdo"}, {31'd0, sdo}, {31'd0, e});
      check("R2 oe in frame", {31'd0, sdo_oe}, 32'd1);
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: pushes predicted sdo bits, then plays the frame
  task automatic frame(input logic [31:0] din, input int nbits, input logic [15:0] stat);
    @(negedge clk);
    status_in = stat;
    cs_n_pin = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      exp_q.push_back(i < 16 ? stat[i] : din[i-16]);
      tag_q.push_back(i == 0 ? "R3" : (i < 16 ? "R5" : "R7"));
    end
    wait_clk(2*HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi_pin = din[i];
      sclk_pin = 1'b1;
      wait_clk(HALF);
      sclk_pin = 1'b0;
      wait_clk(HALF);
    end
    cs_n_pin = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    #(CLK_NS*150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1 ctrl reset", {16'd0, ctrl_q}, 32'h0000E000);
    check("R1 oe reset", {31'd0, sdo_oe}, 32'd0);
    check("R1 clear reset", {31'd0, clear_pulse}, 32'd0);

    // R4 R6 plain write, R3 R5 status readback
    frame(32'h0A56, 16, 16'hC3A5);
    check("R4 ctrl write", {16'd0, ctrl_q}, 32'h0A56);
    check("R2 oe after frame", {31'd0, sdo_oe}, 32'd0);

    // R9 bit 0 set: not stored, single pulse
    frame(32'h807F, 16, 16'h5A0F);
    check("R9 ctrl bit0 dropped", {16'd0, ctrl_q}, 32'h807E);
    check("R9 pulse count", pulses, 1);

    // R6 short frame ignored
    frame(32'h00FF, 8, 16'h3C3C);
    check("R6 short frame", {16'd0, ctrl_q}, 32'h807E);
    check("R6 no pulse", pulses, 1);

    // R3 status bit 0 read with select only
    @(negedge clk);
    status_in = 16'h0001;
    cs_n_pin = 1'b0;
    wait_clk(6);
    check("R3 early bit0", {31'd0, sdo}, 32'd1);
    check("R2 oe early", {31'd0, sdo_oe}, 32'd1);
    cs_n_pin = 1'b1;
    wait_clk(6);
    check("R2 oe released", {31'd0, sdo_oe}, 32'd0);
    check("R6 select-only frame", {16'd0, ctrl_q}, 32'h807E);

    // R8 reserved word refused, boundary accepted
    frame(32'hE081, 16, 16'h0000);
    check("R8 refused ctrl", {16'd0, ctrl_q}, 32'h807E);
    check("R8 refused pulse", pulses, 1);
    frame(32'hE001, 16, 16'hFFFF);
    check("R8 boundary accepted", {16'd0, ctrl_q}, 32'hE000);
    check("R9 pulse on accept", pulses, 2);

    // R7 long frame keeps last 16, sdo forwards sdi
    frame(32'h5A3C7, 20, 16'h9669);
    check("R7 last 16 kept", {16'd0, ctrl_q}, 32'h5A3C);

    // R10 activity with select high
    for (int i = 0; i < 20; i++) begin
      sdi_pin = i[0];
      sclk_pin = 1'b1;
      wait_clk(HALF);
      sclk_pin = 1'b0;
      wait_clk(HALF);
    end
    check("R10 ctrl idle", {16'd0, ctrl_q}, 32'h5A3C);
    check("R10 oe idle", {31'd0, sdo_oe}, 32'd0);
    frame(32'h1234, 16, 16'hA5C3);
    check("R10 next frame clean", {16'd0, ctrl_q}, 32'h1234);
    check("R5 queue drained", exp_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule